// File: doc/BRIEF.md
# Serial Memory Command Front End

This block is the slave side of a four-wire serial link in front of a byte-organised non-volatile memory. It runs entirely in the system clock domain. The serial clock, select, data-in and pause inputs are first brought into that domain through two-flop synchronisers, and all edges are then detected on the synchronised copies. Bits arrive most significant first. The block assembles them into an 8-bit instruction, an optional 16-bit address and data bytes.

The result is a stream of decoded commands on a valid/ready port toward a memory or page-buffer controller. For array reads and status reads, the block issues a fetch command and takes the returned byte on a second valid/ready port. It then shifts that byte out on the serial output. Write-protect policy, programming timing and the array itself sit beyond these two ports.

Command port rules: once `cmd_valid` rises, the op, address and data stay frozen until the cycle in which `cmd_ready` is high. The consumer must accept each command before the serial master completes the next byte. A fetch issued for the output path must be answered on the return port before the next falling serial edge. The return port raises `rd_ready` only while a fetch is outstanding, and a byte offered at any other time is dropped.

Top module: `spi_mem_cmd_front`

## Requirements
- R1: While select (`spi_csn`) is high, `spi_miso_en` is low and serial clock or data activity produces no command.
- R2: Input bits are taken on rising serial clock edges, MSB first. Output bits change on falling edges, MSB first, so the master samples each bit on the following rising edge.
- R3: An instruction byte of the form 0000_x_b2b1b0 (bit 3 ignored) decodes by b2b1b0 as follows: 011 read, 010 write, 110 write-enable, 100 write-disable, 101 status read, 001 status write. On `cmd_op` these appear as read=0, write=1, write-enable=2, write-disable=3, status read=4, status write=5.
- R4: Read and write are followed by a 16-bit address. Only its low `ADDR_BITS` bits (13 by default) reach `cmd_addr`.
- R5: Any other instruction byte locks the frame until select rises and falls again. While locked, `spi_miso_en` stays low and no command is issued.
- R6: A fall of `spi_hold_n` while the serial clock is low pauses the frame, and a rise while the clock is low resumes it. Serial clock edges during the pause are ignored.
- R7: During a read, each completed output byte fetches the next address. The address wraps from the top of the array to 0, for as long as select stays low.
- R8: During a status read, a new status fetch is issued after every 8 clocks, so the status byte repeats while select stays low.
- R9: A command held back by `cmd_ready` low keeps `cmd_valid` high with unchanged fields until accepted.
- R10: Each complete data byte of a write issues one write command, and the address advances by one per byte. A status write issues one command carrying the first data byte and ignores later bits.
- R11: Write-enable and write-disable each issue one command at the end of the instruction byte. Later bits in the same frame are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from master |
| spi_csn | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data in |
| spi_hold_n | input | 1 | Active-low pause |
| spi_miso | output | 1 | Serial data out |
| spi_miso_en | output | 1 | Output enable for `spi_miso`; low means high impedance |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Command accepted |
| cmd_op | output | 3 | Command code (see R3) |
| cmd_addr | output | ADDR_BITS | Byte address |
| cmd_data | output | 8 | Write or status-write byte |
| rd_valid | input | 1 | Fetched byte present |
| rd_ready | output | 1 | Fetch outstanding |
| rd_data | input | 8 | Fetched byte |

## Verification
A bit counter out of step with the master shows up within one byte time. The write byte at `cmd_data` or the byte shifted on `spi_miso` comes out rotated, or the command lands on the wrong clock. A decode or lock fault appears on `cmd_op`, or as an enable on `spi_miso_en` when none should occur, before the frame's next byte finishes. A pause that leaks clock edges corrupts the very byte in which it happens, so the bench pauses in mid-byte. It then compares the written byte bit for bit.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

  typedef enum logic [2:0] {
    CMD_READ  = 3'd0,
    CMD_WRITE = 3'd1,
    CMD_WREN  = 3'd2,
    CMD_WRDI  = 3'd3,
    CMD_RDSR  = 3'd4,
    CMD_WRSR  = 3'd5
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_DIN,
    ST_DOUT,
    ST_DONE,
    ST_LOCK
  } frame_st_e;

  typedef struct packed {
    logic ok;
    cmd_e op;
  } op_dec_t;

  // Upper nibble must be zero; bit 3 is ignored; low three bits pick the op.
  function automatic op_dec_t decode_opcode(input logic [7:0] b);
    op_dec_t r;
    r.ok = (b[7:4] == 4'h0);
    r.op = CMD_READ;
    case (b[2:0])
      3'b011:  r.op = CMD_READ;
      3'b010:  r.op = CMD_WRITE;
      3'b110:  r.op = CMD_WREN;
      3'b100:  r.op = CMD_WRDI;
      3'b101:  r.op = CMD_RDSR;
      3'b001:  r.op = CMD_WRSR;
      default: r.ok = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sfe_sync.sv
module sfe_sync #(
  parameter int N = 4,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic meta;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta <= RST_VAL[i];
        q[i] <= RST_VAL[i];
      end else begin
        meta <= din[i];
        q[i] <= meta;
      end
    end
  end
endmodule

// File: rtl/sfe_edge.sv
module sfe_edge #(
  parameter int N = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] s,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  for (genvar i = 0; i < N; i++) begin : g_det
    logic prev;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= RST_VAL[i];
      else        prev <= s[i];
    end
    assign rise[i] = s[i] & ~prev;
    assign fall[i] = ~s[i] & prev;
  end
endmodule

// File: rtl/sfe_hold_gate.sv
module sfe_hold_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic csn_s,
  input  logic sck_s,
  input  logic sck_rise,
  input  logic sck_fall,
  input  logic hold_rise,
  input  logic hold_fall,
  output logic paused,
  output logic sck_rise_g,
  output logic sck_fall_g
);
  // Pause state changes only while the synchronised clock is low.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     paused <= 1'b0;
    else if (csn_s)                 paused <= 1'b0;
    else if (hold_fall && !sck_s)   paused <= 1'b1;
    else if (hold_rise && !sck_s)   paused <= 1'b0;
  end

  assign sck_rise_g = sck_rise & ~paused & ~csn_s;
  assign sck_fall_g = sck_fall & ~paused & ~csn_s;

  // R6: a pause can only begin from a low clock
  assert_pause_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(paused) |-> !$past(sck_s));
endmodule

// File: rtl/sfe_frame.sv
module sfe_frame
  import sfe_pkg::*;
#(
  parameter int ADDR_BITS = 13
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 csn_s,
  input  logic                 desel,
  input  logic                 sel,
  input  logic                 sck_rise_g,
  input  logic                 sck_fall_g,
  input  logic                 mosi_s,
  input  logic                 paused,
  output logic                 miso,
  output logic                 miso_en,
  output logic                 cmd_valid,
  input  logic                 cmd_ready,
  output cmd_e                 cmd_op,
  output logic [ADDR_BITS-1:0] cmd_addr,
  output logic [7:0]           cmd_data,
  input  logic                 rd_valid,
  input  logic [7:0]           rd_data,
  output logic                 rd_ready
);
  localparam int FRAME_ADDR_BITS = 16;
  localparam int CNT_W = $clog2(FRAME_ADDR_BITS) + 1;
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(7);
  localparam logic [CNT_W-1:0] LAST_ABIT = CNT_W'(FRAME_ADDR_BITS - 1);

  frame_st_e                    state;
  cmd_e                         cur;
  logic [CNT_W-1:0]             bitcnt;
  logic [FRAME_ADDR_BITS-1:0]   shreg;
  logic [ADDR_BITS-1:0]         addr;
  logic [ADDR_BITS-1:0]         addr_nx;
  logic [2:0]                   fcnt;
  logic [7:0]                   out_sh;
  logic [7:0]                   nxt_byte;
  logic [7:0]                   in_byte;
  logic [FRAME_ADDR_BITS-1:0]   addr_word;
  op_dec_t                      opdec;

  assign in_byte   = {shreg[6:0], mosi_s};
  assign addr_word = {shreg[FRAME_ADDR_BITS-2:0], mosi_s};
  assign opdec     = decode_opcode(in_byte);
  assign addr_nx   = addr + ADDR_BITS'(1);
  assign miso_en   = (state == ST_DOUT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cur       <= CMD_READ;
      bitcnt    <= '0;
      shreg     <= '0;
      addr      <= '0;
      fcnt      <= '0;
      out_sh    <= '0;
      nxt_byte  <= '0;
      miso      <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_op    <= CMD_READ;
      cmd_addr  <= '0;
      cmd_data  <= '0;
      rd_ready  <= 1'b0;
    end else begin
      if (cmd_valid && cmd_ready) cmd_valid <= 1'b0;
      if (rd_ready && rd_valid) begin
        nxt_byte <= rd_data;
        rd_ready <= 1'b0;
      end
      if (desel) begin
        state    <= ST_IDLE;
        bitcnt   <= '0;
        rd_ready <= 1'b0;
      end else if (sel) begin
        state  <= ST_OPC;
        bitcnt <= '0;
        fcnt   <= '0;
      end else if (sck_rise_g) begin
        shreg  <= addr_word;
        bitcnt <= bitcnt + CNT_W'(1);
        case (state)
          ST_OPC: if (bitcnt == LAST_BIT) begin
            bitcnt <= '0;
            cur    <= opdec.op;
            if (!opdec.ok) begin
              state <= ST_LOCK;
            end else begin
              case (opdec.op)
                CMD_READ, CMD_WRITE: state <= ST_ADDR;
                CMD_WRSR:            state <= ST_DIN;
                CMD_RDSR: begin
                  state     <= ST_DOUT;
                  fcnt      <= '0;
                  cmd_valid <= 1'b1;
                  cmd_op    <= CMD_RDSR;
                  cmd_data  <= '0;
                  rd_ready  <= 1'b1;
                end
                default: begin
                  state     <= ST_DONE;
                  cmd_valid <= 1'b1;
                  cmd_op    <= opdec.op;
                  cmd_data  <= '0;
                end
              endcase
            end
          end
          ST_ADDR: if (bitcnt == LAST_ABIT) begin
            bitcnt <= '0;
            addr   <= addr_word[ADDR_BITS-1:0];
            if (cur == CMD_READ) begin
              state     <= ST_DOUT;
              fcnt      <= '0;
              cmd_valid <= 1'b1;
              cmd_op    <= CMD_READ;
              cmd_addr  <= addr_word[ADDR_BITS-1:0];
              cmd_data  <= '0;
              rd_ready  <= 1'b1;
            end else begin
              state <= ST_DIN;
            end
          end
          ST_DIN: if (bitcnt == LAST_BIT) begin
            bitcnt    <= '0;
            cmd_valid <= 1'b1;
            cmd_op    <= cur;
            cmd_data  <= in_byte;
            if (cur == CMD_WRITE) begin
              cmd_addr <= addr;
              addr     <= addr_nx;
            end else begin
              state <= ST_DONE;
            end
          end
          ST_DOUT: if (bitcnt == LAST_BIT) begin
            bitcnt    <= '0;
            cmd_valid <= 1'b1;
            cmd_op    <= cur;
            cmd_data  <= '0;
            rd_ready  <= 1'b1;
            if (cur == CMD_READ) begin
              cmd_addr <= addr_nx;
              addr     <= addr_nx;
            end
          end
          default: bitcnt <= '0;
        endcase
      end else if (sck_fall_g && state == ST_DOUT) begin
        fcnt <= fcnt + 3'd1;
        if (fcnt == 3'd0) begin
          miso   <= nxt_byte[7];
          out_sh <= {nxt_byte[6:0], 1'b0};
        end else begin
          miso   <= out_sh[7];
          out_sh <= {out_sh[6:0], 1'b0};
        end
      end
    end
  end

  // R1: output stays released while deselected
  assert_quiet_deselected_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (csn_s && $past(csn_s)) |-> !miso_en);

  // R5: a locked frame stays locked until deselect
  assert_lock_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOCK && !desel) |=> (state == ST_LOCK));

  // R5: nothing is issued from a locked frame
  assert_lock_no_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOCK && !cmd_valid) |=> !cmd_valid);

  // R6: a paused frame does not advance its bit position
  assert_pause_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (paused && !desel && !sel) |=> ($stable(bitcnt) && $stable(shreg)));

  // R9: a waiting command holds its fields
  assert_cmd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) &&
                                   $stable(cmd_addr) && $stable(cmd_data)));
endmodule

// File: rtl/spi_mem_cmd_front.sv
module spi_mem_cmd_front
  import sfe_pkg::*;
#(
  parameter int ADDR_BITS = 13
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 spi_sck,
  input  logic                 spi_csn,
  input  logic                 spi_mosi,
  input  logic                 spi_hold_n,
  output logic                 spi_miso,
  output logic                 spi_miso_en,
  output logic                 cmd_valid,
  input  logic                 cmd_ready,
  output logic [2:0]           cmd_op,
  output logic [ADDR_BITS-1:0] cmd_addr,
  output logic [7:0]           cmd_data,
  input  logic                 rd_valid,
  output logic                 rd_ready,
  input  logic [7:0]           rd_data
);
  localparam int N_SYNC = 4;
  localparam int N_EDGE = N_SYNC - 1;
  localparam logic [N_SYNC-1:0] SYNC_RST = 4'b1110; // hold, mosi, csn, sck

  logic [N_SYNC-1:0] sync_q;
  logic [N_EDGE-1:0] rise, fall;
  logic sck_s, csn_s, mosi_s, hold_s;
  logic paused, sck_rise_g, sck_fall_g;
  cmd_e op_int;

  sfe_sync #(.N(N_SYNC), .RST_VAL(SYNC_RST)) u_sync (
    .clk (clk), .rst_n (rst_n),
    .din ({spi_hold_n, spi_mosi, spi_csn, spi_sck}),
    .q   (sync_q)
  );

  assign {hold_s, mosi_s, csn_s, sck_s} = sync_q;

  sfe_edge #(.N(N_EDGE), .RST_VAL(3'b110)) u_edge (
    .clk (clk), .rst_n (rst_n),
    .s   ({hold_s, csn_s, sck_s}),
    .rise(rise), .fall(fall)
  );

  sfe_hold_gate u_hold (
    .clk (clk), .rst_n (rst_n),
    .csn_s (csn_s), .sck_s (sck_s),
    .sck_rise (rise[0]), .sck_fall (fall[0]),
    .hold_rise (rise[2]), .hold_fall (fall[2]),
    .paused (paused), .sck_rise_g (sck_rise_g), .sck_fall_g (sck_fall_g)
  );

  sfe_frame #(.ADDR_BITS(ADDR_BITS)) u_frame (
    .clk (clk), .rst_n (rst_n),
    .csn_s (csn_s), .desel (rise[1]), .sel (fall[1]),
    .sck_rise_g (sck_rise_g), .sck_fall_g (sck_fall_g),
    .mosi_s (mosi_s), .paused (paused),
    .miso (spi_miso), .miso_en (spi_miso_en),
    .cmd_valid (cmd_valid), .cmd_ready (cmd_ready),
    .cmd_op (op_int), .cmd_addr (cmd_addr), .cmd_data (cmd_data),
    .rd_valid (rd_valid), .rd_data (rd_data), .rd_ready (rd_ready)
  );

  assign cmd_op = op_int;
endmodule

// File: tb/spi_mem_cmd_front_test.sv
module spi_mem_cmd_front_test;
  localparam int AB = 13;
  localparam int H  = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, csn = 1'b1, mosi = 1'b1, hold_n = 1'b1;
  logic miso, miso_en, cmd_valid, rd_ready;
  logic cmd_ready = 1'b1;
  logic [2:0] cmd_op;
  logic [AB-1:0] cmd_addr;
  logic [7:0] cmd_data;
  logic rd_valid;
  logic [7:0] rd_data;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  spi_mem_cmd_front #(.ADDR_BITS(AB)) uut (
    .clk (clk), .rst_n (rst_n),
    .spi_sck (sck), .spi_csn (csn), .spi_mosi (mosi), .spi_hold_n (hold_n),
    .spi_miso (miso), .spi_miso_en (miso_en),
    .cmd_valid (cmd_valid), .cmd_ready (cmd_ready),
    .cmd_op (cmd_op), .cmd_addr (cmd_addr), .cmd_data (cmd_data),
    .rd_valid (rd_valid), .rd_ready (rd_ready), .rd_data (rd_data)
  );

  // Memory model: logs accepted commands, answers fetches.
  logic [2:0]    lg_op   [64];
  logic [AB-1:0] lg_addr [64];
  logic [7:0]    lg_data [64];
  int log_n = 0;
  logic [7:0] status_reg;

  function automatic logic [7:0] pattern(input logic [AB-1:0] a);
    return a[7:0] ^ {a[12:8], 3'b101};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      rd_valid   <= 1'b0;
      rd_data    <= 8'h00;
      status_reg <= 8'h00;
    end else begin
      rd_valid <= 1'b0;
      if (cmd_valid && cmd_ready) begin
        lg_op[log_n[5:0]]   <= cmd_op;
        lg_addr[log_n[5:0]] <= cmd_addr;
        lg_data[log_n[5:0]] <= cmd_data;
        log_n <= log_n + 1;
        if (cmd_op == 3'd0) begin rd_valid <= 1'b1; rd_data <= pattern(cmd_addr); end
        if (cmd_op == 3'd4) begin rd_valid <= 1'b1; rd_data <= status_reg; end
        if (cmd_op == 3'd5) status_reg <= cmd_data;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_bit(input logic b, output logic r);
    mosi = b;
    wait_clk(H);
    r = miso;
    sck = 1'b1;
    wait_clk(H);
    sck = 1'b0;
  endtask

  task automatic spi_xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) spi_bit(tx[i], rx[i]);
  endtask

  task automatic frame_open();
    csn = 1'b0;
    wait_clk(H);
  endtask

  task automatic frame_close();
    wait_clk(H);
    csn = 1'b1;
    wait_clk(3 * H);
  endtask

  task automatic t_reset();
    chk("R1 reset miso_en", miso_en, 0);
    chk("R1 reset cmd_valid", cmd_valid, 0);
    chk("R1 reset rd_ready", rd_ready, 0);
  endtask

  task automatic t_enable_disable();
    logic [7:0] rx;
    int b = log_n;
    frame_open(); spi_xfer(8'h06, rx); spi_xfer(8'hFF, rx); frame_close();
    frame_open(); spi_xfer(8'h0C, rx); frame_close();
    chk("R11 count", log_n - b, 2);
    chk("R3 R11 write-enable op", lg_op[b[5:0]], 2);
    chk("R3 write-disable with bit3 set", lg_op[6'(b + 1)], 3);
  endtask

  task automatic t_write_stream();
    logic [7:0] rx;
    int b = log_n;
    frame_open();
    spi_xfer(8'h0A, rx); spi_xfer(8'hFF, rx); spi_xfer(8'h34, rx);
    spi_xfer(8'hA5, rx); spi_xfer(8'h5A, rx);
    frame_close();
    chk("R10 write count", log_n - b, 2);
    chk("R3 write op", lg_op[b[5:0]], 1);
    chk("R4 write addr masked", lg_addr[b[5:0]], 13'h1F34);
    chk("R2 R10 first data", lg_data[b[5:0]], 8'hA5);
    chk("R10 second addr", lg_addr[6'(b + 1)], 13'h1F35);
    chk("R10 second data", lg_data[6'(b + 1)], 8'h5A);
  endtask

  task automatic t_read_wrap();
    logic [7:0] rx;
    int b = log_n;
    frame_open();
    spi_xfer(8'h03, rx); spi_xfer(8'hFF, rx); spi_xfer(8'hFE, rx);
    chk("R2 miso_en during read", miso_en, 1);
    spi_xfer(8'h00, rx); chk("R2 R7 byte0", rx, pattern(13'h1FFE));
    spi_xfer(8'h00, rx); chk("R7 byte1", rx, pattern(13'h1FFF));
    spi_xfer(8'h00, rx); chk("R7 wrap byte", rx, pattern(13'h0000));
    frame_close();
    chk("R4 read addr masked", lg_addr[b[5:0]], 13'h1FFE);
    chk("R7 wrap fetch addr", lg_addr[6'(b + 2)], 13'h0000);
    chk("R1 released after frame", miso_en, 0);
  endtask

  task automatic t_status();
    logic [7:0] rx;
    int b = log_n;
    frame_open(); spi_xfer(8'h01, rx); spi_xfer(8'h8C, rx); spi_xfer(8'h33, rx); frame_close();
    chk("R10 status write single cmd", log_n - b, 1);
    chk("R3 status write op", lg_op[b[5:0]], 5);
    chk("R10 status write data", lg_data[b[5:0]], 8'h8C);
    frame_open(); spi_xfer(8'h05, rx);
    spi_xfer(8'h00, rx); chk("R8 status first", rx, 8'h8C);
    spi_xfer(8'h00, rx); chk("R8 status repeat", rx, 8'h8C);
    frame_close();
    chk("R3 status read op", lg_op[6'(b + 1)], 4);
  endtask

  task automatic t_lockout();
    logic [7:0] rx;
    int b = log_n;
    frame_open();
    spi_xfer(8'hF3, rx);
    chk("R5 locked miso_en", miso_en, 0);
    spi_xfer(8'h06, rx); spi_xfer(8'h02, rx);
    chk("R5 still locked miso_en", miso_en, 0);
    frame_close();
    chk("R5 no commands", log_n - b, 0);
    frame_open(); spi_xfer(8'h06, rx); frame_close();
    chk("R5 new frame decodes", lg_op[b[5:0]], 2);
  endtask

  task automatic t_hold();
    logic [7:0] rx;
    logic r;
    int b = log_n;
    frame_open();
    spi_xfer(8'h02, rx); spi_xfer(8'h00, rx); spi_xfer(8'h10, rx);
    for (int i = 7; i >= 4; i--) spi_bit(1'(8'h3C >> i), r);
    hold_n = 1'b0; wait_clk(H);
    for (int k = 0; k < 3; k++) spi_bit(1'b1, r);
    hold_n = 1'b1; wait_clk(H);
    for (int i = 3; i >= 0; i--) spi_bit(1'(8'h3C >> i), r);
    frame_close();
    chk("R6 one write", log_n - b, 1);
    chk("R6 data intact", lg_data[b[5:0]], 8'h3C);
    chk("R6 addr", lg_addr[b[5:0]], 13'h0010);
  endtask

  task automatic t_deselected();
    logic r;
    int b = log_n;
    for (int i = 0; i < 16; i++) spi_bit(1'(i & 1), r);
    chk("R1 no cmd while deselected", log_n - b, 0);
    chk("R1 miso_en while deselected", miso_en, 0);
  endtask

  task automatic t_backpressure();
    logic [7:0] rx;
    int b = log_n;
    cmd_ready = 1'b0;
    frame_open(); spi_xfer(8'h06, rx); frame_close();
    chk("R9 valid held", cmd_valid, 1);
    chk("R9 op held", cmd_op, 2);
    wait_clk(20);
    chk("R9 still valid", cmd_valid, 1);
    cmd_ready = 1'b1;
    wait_clk(3);
    chk("R9 accepted", cmd_valid, 0);
    chk("R9 accepted once", log_n - b, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);
    t_reset();
    t_enable_disable();
    t_write_stream();
    t_read_wrap();
    t_status();
    t_lockout();
    t_hold();
    t_deselected();
    t_backpressure();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule